// File: doc/BRIEF.md
# Machine-Cycle Timer and Falling-Edge Event Counter

This block holds a pair of byte registers that together form one count. The oscillator clock is divided into machine cycles of twelve clocks. In timer operation the count advances once per machine cycle. In counter operation it advances once for each high-to-low change of an external pin. That pin is sampled once per machine cycle, so a change is recognised only from two consecutive samples. A run enable gates all counting, and a select input picks timer or counter operation.

A two-bit shape field gives the count one of four forms: a 13-bit count whose low five bits act as a prescaler, a full 16-bit count, an 8-bit count that reloads itself from the high byte, and a split form in which the two bytes run as independent 8-bit counts. The split form has its own run enable and its own overflow flag for the high byte. Software loads either byte through a shared write data port, reads both bytes directly, and clears each overflow flag with a strobe.

The reset input is asynchronous, active low, and assumed to be released in step with the clock.

Top module: `tmr_evt_unit`

## Requirements
- R1: With `cnt_sel`=0 and `run_en`=1, the count advances by exactly one per 12 clocks; a window of 12*K consecutive clocks with run high gives exactly K advances.
- R2: With `cnt_sel`=1, the count advances once for each falling edge of `ev_pin` seen by two consecutive once-per-machine-cycle samples. A level held for 24 clocks or more is always seen. A steady level never counts, and a pulse that falls between two samples is ignored. The new value shows up within the machine cycle after the sample that saw the fall.
- R3: `mode_sel`=00 gives a 13-bit count. `rd_lo[4:0]` is the prescaler, and a carry out of it advances `rd_hi`. `rd_lo[7:5]` is left unchanged. Overflow occurs when `rd_hi`=FF and `rd_lo[4:0]`=1F.
- R4: `mode_sel`=10 gives an 8-bit auto-reload count. `rd_lo` counts, and when it steps past FF it is loaded with `rd_hi` and `ovf_flag` is set. `rd_hi` never changes by counting.
- R5: `mode_sel`=01 gives a 16-bit count {`rd_hi`,`rd_lo`}, and a step from FFFF to 0000 sets `ovf_flag`.
- R6: `mode_sel`=11 gives the split form. `rd_lo` is an 8-bit count under `run_en`/`cnt_sel` and sets `ovf_flag` on wrap. `rd_hi` is an 8-bit machine-cycle timer under `run2_en` and sets `ovf2_flag` on wrap. In all other modes `run2_en` has no effect.
- R7: While the run enable of a byte is low, that byte does not count.
- R8: `wr_lo`/`wr_hi` load `wdata` into the byte at the next clock, and the load takes priority over a count step in the same clock.
- R9: After reset, both bytes and both flags read 0.
- R10: `clr_ovf`/`clr_ovf2` clear their flag at the next clock. A flag being set in the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pin | input | 1 | External event input |
| run_en | input | 1 | Run enable for the main count (low byte in split form) |
| run2_en | input | 1 | Run enable for the high byte in split form |
| cnt_sel | input | 1 | 1: count pin falls, 0: count machine cycles |
| mode_sel | input | 2 | Count shape: 00 13-bit, 01 16-bit, 10 auto-reload, 11 split |
| wr_lo | input | 1 | Load `wdata` into the low byte |
| wr_hi | input | 1 | Load `wdata` into the high byte |
| wdata | input | 8 | Write data |
| clr_ovf | input | 1 | Clear `ovf_flag` |
| clr_ovf2 | input | 1 | Clear `ovf2_flag` |
| rd_lo | output | 8 | Low byte value |
| rd_hi | output | 8 | High byte value |
| ovf_flag | output | 1 | Main overflow flag |
| ovf2_flag | output | 1 | High byte overflow flag (split form) |

## Verification
Two cases are hard to reach from the ports: a write and a count step landing on the same clock edge, and a flag clear coinciding with a wrap. Both need knowledge of the internal machine-cycle phase. The bench keeps its own count of clocks since reset release and uses it to place those strobes on the step edge. It uses the same count to place a short pin pulse wholly between two sample points, which shows that a pulse missed by the samples is not counted.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SHAPE_13  = 2'b00,
    SHAPE_16  = 2'b01,
    SHAPE_RLD = 2'b10,
    SHAPE_SPL = 2'b11
  } shape_e;
endpackage

// File: rtl/tmr_phase_gen.sv
module tmr_phase_gen #(
  parameter int CYC_LEN   = 12,
  parameter int SMP_PHASE = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic step_o,
  output logic smp_o
);
  localparam int PHW = $clog2(CYC_LEN);
  localparam logic [PHW-1:0] LAST = PHW'(CYC_LEN - 1);
  localparam logic [PHW-1:0] SMP  = PHW'(SMP_PHASE);

  logic [PHW-1:0] ph_q, ph_n;

  always_comb begin
    if (ph_q == LAST) ph_n = '0;
    else              ph_n = ph_q + PHW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_n;
  end

  assign step_o = (ph_q == LAST);
  assign smp_o  = (ph_q == SMP);
endmodule

// File: rtl/tmr_edge_smp.sv
module tmr_edge_smp #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic smp_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic cur_q, prev_q;
  logic cur_n, prev_n;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
    end
  endgenerate

  always_comb begin
    cur_n  = cur_q;
    prev_n = prev_q;
    if (smp_i) begin
      cur_n  = sync_q[SYNC_STAGES-1];
      prev_n = cur_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cur_q  <= cur_n;
      prev_q <= prev_n;
    end
  end

  assign fall_o = prev_q & ~cur_q;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int BW = 8,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  shape_e        shape_i,
  input  logic          inc_main_i,
  input  logic          inc_hi_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [BW-1:0] wdata_i,
  input  logic          clr0_i,
  input  logic          clr1_i,
  output logic [BW-1:0] lo_o,
  output logic [BW-1:0] hi_o,
  output logic          f0_o,
  output logic          f1_o
);
  localparam logic [BW-1:0]   B_ONE  = BW'(1);
  localparam logic [BW-1:0]   B_ALL  = '1;
  localparam logic [PW-1:0]   P_ONE  = PW'(1);
  localparam logic [PW-1:0]   P_ALL  = '1;
  localparam logic [2*BW-1:0] W_ONE  = (2*BW)'(1);

  logic [BW-1:0] lo_q, hi_q, lo_n, hi_n;
  logic          f0_q, f1_q, f0_n, f1_n;
  logic          set0, set1;
  logic [2*BW-1:0] wide;

  always_comb begin
    lo_n = lo_q;
    hi_n = hi_q;
    set0 = 1'b0;
    set1 = 1'b0;
    wide = {hi_q, lo_q} + W_ONE;
    case (shape_i)
      SHAPE_13: if (inc_main_i) begin
        if (lo_q[PW-1:0] == P_ALL) begin
          lo_n[PW-1:0] = '0;
          hi_n         = hi_q + B_ONE;
          set0         = (hi_q == B_ALL);
        end else begin
          lo_n[PW-1:0] = lo_q[PW-1:0] + P_ONE;
        end
      end
      SHAPE_16: if (inc_main_i) begin
        {hi_n, lo_n} = wide;
        set0         = ({hi_q, lo_q} == {B_ALL, B_ALL});
      end
      SHAPE_RLD: if (inc_main_i) begin
        if (lo_q == B_ALL) begin
          lo_n = hi_q;
          set0 = 1'b1;
        end else begin
          lo_n = lo_q + B_ONE;
        end
      end
      default: begin
        if (inc_main_i) begin
          lo_n = lo_q + B_ONE;
          set0 = (lo_q == B_ALL);
        end
        if (inc_hi_i) begin
          hi_n = hi_q + B_ONE;
          set1 = (hi_q == B_ALL);
        end
      end
    endcase
    if (wr_lo_i) lo_n = wdata_i;
    if (wr_hi_i) hi_n = wdata_i;
    f0_n = set0 | (f0_q & ~clr0_i);
    f1_n = set1 | (f1_q & ~clr1_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      f0_q <= 1'b0;
      f1_q <= 1'b0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
      f0_q <= f0_n;
      f1_q <= f1_n;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
  assign f0_o = f0_q;
  assign f1_o = f1_q;
endmodule

// File: rtl/tmr_evt_unit.sv
module tmr_evt_unit
  import tmr_pkg::*;
#(
  parameter int CYC_LEN     = 12,
  parameter int SMP_PHASE   = 5,
  parameter int SYNC_STAGES = 2,
  parameter int BW          = 8,
  parameter int PW          = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_pin,
  input  logic          run_en,
  input  logic          run2_en,
  input  logic          cnt_sel,
  input  logic [1:0]    mode_sel,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  input  logic          clr_ovf,
  input  logic          clr_ovf2,
  output logic [BW-1:0] rd_lo,
  output logic [BW-1:0] rd_hi,
  output logic          ovf_flag,
  output logic          ovf2_flag
);
  logic step_w, smp_w, fall_w;
  logic inc_main_w, inc_hi_w;
  shape_e shape_w;

  tmr_phase_gen #(.CYC_LEN(CYC_LEN), .SMP_PHASE(SMP_PHASE)) u_phase (
    .clk(clk), .rst_n(rst_n), .step_o(step_w), .smp_o(smp_w)
  );

  tmr_edge_smp #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(ev_pin), .smp_i(smp_w), .fall_o(fall_w)
  );

  assign shape_w    = shape_e'(mode_sel);
  assign inc_main_w = run_en & step_w & (cnt_sel ? fall_w : 1'b1);
  assign inc_hi_w   = run2_en & step_w & (shape_w == SHAPE_SPL);

  tmr_count_core #(.BW(BW), .PW(PW)) u_core (
    .clk(clk), .rst_n(rst_n), .shape_i(shape_w),
    .inc_main_i(inc_main_w), .inc_hi_i(inc_hi_w),
    .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(wdata),
    .clr0_i(clr_ovf), .clr1_i(clr_ovf2),
    .lo_o(rd_lo), .hi_o(rd_hi), .f0_o(ovf_flag), .f1_o(ovf2_flag)
  );
endmodule

// File: rtl/tmr_evt_chk.sv
module tmr_evt_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_en,
  input logic          run2_en,
  input logic [1:0]    mode_sel,
  input logic          wr_lo,
  input logic          wr_hi,
  input logic [BW-1:0] wdata,
  input logic          step,
  input logic [BW-1:0] rd_lo,
  input logic [BW-1:0] rd_hi,
  input logic          ovf_flag,
  input logic          ovf2_flag
);
  // R1: low byte only moves on a machine-cycle step or a write
  p_lo_moves_on_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_lo) |=> $stable(rd_lo));

  // R4: reload value is never changed by counting
  p_reload_hi_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10 && !wr_hi) |=> $stable(rd_hi));

  // R5: main flag rises only after a step
  p_flag_after_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(step));

  // R6: second flag rises only after a step in split form
  p_flag2_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf2_flag) |-> ($past(step) && $past(mode_sel) == 2'b11));

  // R7: nothing moves while stopped and not written
  p_hold_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !run2_en && !wr_lo && !wr_hi) |=> $stable({rd_hi, rd_lo}));

  // R8: a write lands in the next clock
  p_write_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (rd_lo == $past(wdata)));
endmodule

bind tmr_evt_unit tmr_evt_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .run2_en(run2_en),
  .mode_sel(mode_sel), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wdata),
  .step(step_w), .rd_lo(rd_lo), .rd_hi(rd_hi),
  .ovf_flag(ovf_flag), .ovf2_flag(ovf2_flag)
);

// File: tb/tmr_evt_unit_test.sv
`timescale 1ns/1ps
module tmr_evt_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_pin = 1'b0, run_en = 1'b0, run2_en = 1'b0, cnt_sel = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic wr_lo = 1'b0, wr_hi = 1'b0, clr_ovf = 1'b0, clr_ovf2 = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rd_lo, rd_hi;
  logic ovf_flag, ovf2_flag;
  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  tmr_evt_unit uut (.*);

  typedef struct packed {
    logic [1:0] m; logic [7:0] hi0, lo0; logic [3:0] k; logic r1, r2;
    logic [7:0] ehi, elo; logic eo0, eo1;
  } vec_t;
  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{2'd0, 8'h00, 8'h1E, 4'd3, 1'b1, 1'b0, 8'h01, 8'h01, 1'b0, 1'b0}, // R3
    '{2'd0, 8'h00, 8'hFE, 4'd3, 1'b1, 1'b0, 8'h01, 8'hE1, 1'b0, 1'b0}, // R3
    '{2'd0, 8'hFF, 8'h1F, 4'd1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0}, // R3
    '{2'd1, 8'h12, 8'hFF, 4'd2, 1'b1, 1'b0, 8'h13, 8'h01, 1'b0, 1'b0}, // R5
    '{2'd1, 8'hFF, 8'hFE, 4'd3, 1'b1, 1'b0, 8'h00, 8'h01, 1'b1, 1'b0}, // R5
    '{2'd2, 8'hF0, 8'hFE, 4'd3, 1'b1, 1'b0, 8'hF0, 8'hF1, 1'b1, 1'b0}, // R4
    '{2'd2, 8'h80, 8'h10, 4'd4, 1'b1, 1'b0, 8'h80, 8'h14, 1'b0, 1'b0}, // R1
    '{2'd3, 8'h55, 8'hFF, 4'd2, 1'b1, 1'b0, 8'h55, 8'h01, 1'b1, 1'b0}, // R6
    '{2'd3, 8'hFE, 8'h33, 4'd3, 1'b0, 1'b1, 8'h01, 8'h33, 1'b0, 1'b1}, // R6
    '{2'd3, 8'h10, 8'h20, 4'd2, 1'b1, 1'b1, 8'h12, 8'h22, 1'b0, 1'b0}, // R6
    '{2'd1, 8'h00, 8'h05, 4'd3, 1'b0, 1'b0, 8'h00, 8'h05, 1'b0, 1'b0}, // R7
    '{2'd1, 8'h00, 8'h00, 4'd2, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0}  // R6
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic load(input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk); wr_hi = 1'b1; wdata = hi;
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; wdata = lo;
    @(negedge clk); wr_lo = 1'b0; clr_ovf = 1'b1; clr_ovf2 = 1'b1;
    @(negedge clk); clr_ovf = 1'b0; clr_ovf2 = 1'b0;
  endtask

  task automatic sync_to(input int m);
    while (cyc % 12 != m) @(negedge clk);
  endtask

  task automatic pin_level(input logic v, input int n);
    ev_pin = v;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset bytes", {rd_hi, rd_lo}, 16'h0000);
    chk("R9 reset flags", {14'd0, ovf_flag, ovf2_flag}, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cnt_sel = 1'b0;
      mode_sel = VT[i].m;
      load(VT[i].hi0, VT[i].lo0);
      run_en = VT[i].r1; run2_en = VT[i].r2;
      repeat (12 * int'(VT[i].k)) @(posedge clk);
      @(negedge clk); run_en = 1'b0; run2_en = 1'b0;
      chk($sformatf("R1 vec%0d bytes", i), {rd_hi, rd_lo}, {VT[i].ehi, VT[i].elo});
      chk($sformatf("R5 vec%0d flags", i), {14'd0, ovf_flag, ovf2_flag},
          {14'd0, VT[i].eo0, VT[i].eo1});
    end

    // R2: five full pulses, each level held 24 clocks
    mode_sel = 2'b01; cnt_sel = 1'b1;
    load(8'h00, 8'h00);
    run_en = 1'b1;
    for (int p = 0; p < 5; p++) begin
      pin_level(1'b1, 24);
      pin_level(1'b0, 24);
    end
    repeat (36) @(negedge clk);
    chk("R2 five falls", {rd_hi, rd_lo}, 16'h0005);
    pin_level(1'b1, 60);
    chk("R2 steady high no count", {rd_hi, rd_lo}, 16'h0005);
    pin_level(1'b0, 36);
    chk("R2 fall after long high", {rd_hi, rd_lo}, 16'h0006);
    // R2: pulse of two clocks between sample points is ignored
    sync_to(7);
    ev_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    ev_pin = 1'b0;
    repeat (48) @(negedge clk);
    chk("R2 short pulse ignored", {rd_hi, rd_lo}, 16'h0006);
    run_en = 1'b0; cnt_sel = 1'b0;

    // R8: write wins over a step on the same edge
    load(8'h00, 8'h10);
    sync_to(11);
    run_en = 1'b1; wr_lo = 1'b1; wdata = 8'h40;
    @(negedge clk);
    run_en = 1'b0; wr_lo = 1'b0;
    chk("R8 write beats step", {8'h00, rd_lo}, 16'h0040);

    // R10: set wins over clear in the same clock, then clear alone
    load(8'hFF, 8'hFF);
    sync_to(11);
    run_en = 1'b1; clr_ovf = 1'b1;
    @(negedge clk);
    run_en = 1'b0; clr_ovf = 1'b0;
    chk("R10 set beats clear", {15'd0, ovf_flag}, 16'h0001);
    clr_ovf = 1'b1;
    @(negedge clk); clr_ovf = 1'b0;
    chk("R10 clear", {15'd0, ovf_flag}, 16'h0000);

    // R9: reset mid-run
    load(8'hAB, 8'hCD);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset mid-run", {rd_hi, rd_lo}, 16'h0000);
    rst_n = 1'b1;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule